// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits next to a two-port memory and gives each port an active-low interrupt flag, so the two sides can signal each other. Each side has a mailbox word at a fixed address near the top of the address space. A port notifies its partner by writing the message into the partner's mailbox word. That write sets the partner's flag. The partner collects the message by accessing its own mailbox word with its output enable active, and that access clears its flag.

The mailbox words are ordinary memory locations, and the block never stops a write from reaching them. The block also gates each port's memory write strobe, so that no write goes through while that port's busy input is active. A global enable switches the mailbox feature off. While the enable is low, both flags are held deasserted and the memory still behaves normally.

All decisions are taken on the rising clock edge from the port signals sampled at that edge. The flags are registered and change one cycle after the access that causes the change. The write enables to the memory are combinational.

Top module: `mbx_irq`

## Requirements
- R1: After reset, both `lIntN` and `rIntN` read 1, which means deasserted.
- R2: A port is selected only when its `Ce0N` is 0 and its `Ce1` is 1. It writes when it is selected and its `RwN` is 0. A right-port write to address all-ones-minus-one, with `rBusyN` = 1 and `mbxEn` = 1, drives `lIntN` to 0 after the next rising edge.
- R3: The left port clears its flag by being selected with `lOeN` = 0 at address all-ones-minus-one. `lRwN` may be 0 or 1. `lIntN` then returns to 1 after the edge.
- R4: The same rules apply to the right port at the all-ones address. A left-port write there drives `rIntN` to 0. A right-port access there with `rOeN` = 0 drives `rIntN` back to 1.
- R5: An access on an unselected port sets no flag, clears no flag and gives no write enable. A port is unselected when `Ce0N` = 1 or `Ce1` = 0.
- R6: When a port's `BusyN` is 0, its write sets no flag and its `MemWe` output is 0.
- R7: A selected access to a port's own mailbox with `OeN` = 1 does not clear that port's flag.
- R8: If a flag is set and cleared in the same cycle, it ends up asserted.
- R9: When `mbxEn` is 0, both flags go to 1 after the next edge and stay there. Writes to mailbox addresses still assert `MemWe`.
- R10: `MemWe` is 1 in the same cycle as any selected write whose `BusyN` is 1, at any address, mailbox words included.
- R11: Some writes raise no flag: a write to a non-mailbox address, and a port writing its own mailbox address.
- R12: When there is no set and no clear, each flag keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mbxEn | input | 1 | Mailbox feature enable |
| lCe0N | input | 1 | Left first chip enable, active low |
| lCe1 | input | 1 | Left second chip enable, active high |
| lOeN | input | 1 | Left output enable, active low |
| lRwN | input | 1 | Left read/write, 0 = write |
| lBusyN | input | 1 | Left busy, active low |
| lAddr | input | ADDR_W | Left address |
| rCe0N | input | 1 | Right first chip enable, active low |
| rCe1 | input | 1 | Right second chip enable, active high |
| rOeN | input | 1 | Right output enable, active low |
| rRwN | input | 1 | Right read/write, 0 = write |
| rBusyN | input | 1 | Right busy, active low |
| rAddr | input | ADDR_W | Right address |
| lMemWe | output | 1 | Gated left write enable to the memory |
| rMemWe | output | 1 | Gated right write enable to the memory |
| lIntN | output | 1 | Left interrupt flag, active low |
| rIntN | output | 1 | Right interrupt flag, active low |

## Verification
Some rules are checked by the assertions on every cycle:
- a busy or unselected port never produces a set strobe or a write enable;
- a set strobe always leaves the flag asserted, even against a clear in the same cycle;
- a lone clear drops the flag;
- a quiet cycle holds the flag;
- a low enable empties both flags.

Other points can only be shown by the bench's scenarios:
- the address decoding: which of the two top addresses belongs to which side, and that a port writing its own mailbox or an ordinary word raises nothing;
- that a clear happens only with the output enable active, whatever the read/write line shows;
- that mailbox writes still reach the memory while the feature is off.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Index of each side in the per-port arrays
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;

  // Strobes from control to flag datapath
  typedef struct packed {
    logic setL;
    logic clrL;
    logic setR;
    logic clrR;
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter int ADDR_W = 19,
  parameter logic [ADDR_W-1:0] OWN_BOX = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic              ce0N,
  input  logic              ce1,
  input  logic              oeN,
  input  logic              rwN,
  input  logic              busyN,
  input  logic [ADDR_W-1:0] addr,
  output logic              memWe,
  output logic              postHit,
  output logic              drainHit
);
  logic sel;

  always_comb begin
    sel      = !ce0N && ce1;
    // busy on this port blocks the write completely
    memWe    = sel && !rwN && busyN;
    // a gated write into the partner's mailbox notifies it
    postHit  = memWe && (addr == PEER_BOX);
    // output-enabled access to own mailbox collects; rwN is ignored
    drainHit = sel && !oeN && (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   mbxEn,
  input  logic [1:0]             ce0N,
  input  logic [1:0]             ce1,
  input  logic [1:0]             oeN,
  input  logic [1:0]             rwN,
  input  logic [1:0]             busyN,
  input  logic [1:0][ADDR_W-1:0] addr,
  output logic [1:0]             memWe,
  output mbxStrobe_t             str
);
  localparam logic [ADDR_W-1:0] TOP_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LOW_BOX = TOP_BOX ^ ADDR_W'(1);

  logic [1:0] postHit;
  logic [1:0] drainHit;

  for (genvar gi = 0; gi < 2; gi++) begin : g_side
    // left owns the lower mailbox, right owns the top one
    localparam logic [ADDR_W-1:0] OWN  = (gi == SIDE_L) ? LOW_BOX : TOP_BOX;
    localparam logic [ADDR_W-1:0] PEER = (gi == SIDE_L) ? TOP_BOX : LOW_BOX;
    mbx_port_dec #(
      .ADDR_W  (ADDR_W),
      .OWN_BOX (OWN),
      .PEER_BOX(PEER)
    ) u_dec (
      .ce0N    (ce0N[gi]),
      .ce1     (ce1[gi]),
      .oeN     (oeN[gi]),
      .rwN     (rwN[gi]),
      .busyN   (busyN[gi]),
      .addr    (addr[gi]),
      .memWe   (memWe[gi]),
      .postHit (postHit[gi]),
      .drainHit(drainHit[gi])
    );
  end

  always_comb begin
    str.setL = postHit[SIDE_R] && mbxEn;
    str.clrL = drainHit[SIDE_L];
    str.setR = postHit[SIDE_L] && mbxEn;
    str.clrR = drainHit[SIDE_R];
  end

  // R6
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyN[SIDE_R] |-> (!str.setL && !memWe[SIDE_R]));

  // R6
  busy_gate_l_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyN[SIDE_L] |-> (!str.setR && !memWe[SIDE_L]));

  // R5
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ce0N[SIDE_L] || !ce1[SIDE_L]) |-> (!memWe[SIDE_L] && !str.setR && !str.clrL));
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mbxEn,
  input  mbxStrobe_t str,
  output logic       lIntN,
  output logic       rIntN
);
  logic [1:0] setV;
  logic [1:0] clrV;
  logic [1:0] pend;

  always_comb begin
    setV[SIDE_L] = str.setL;
    setV[SIDE_R] = str.setR;
    clrV[SIDE_L] = str.clrL;
    clrV[SIDE_R] = str.clrR;
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN || !mbxEn) pend[gi] <= 1'b0;
      else if (setV[gi])   pend[gi] <= 1'b1;   // set has priority
      else if (clrV[gi])   pend[gi] <= 1'b0;
    end
  end

  assign lIntN = !pend[SIDE_L];
  assign rIntN = !pend[SIDE_R];

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mbxEn && str.setL) |=> !lIntN);

  // R3
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mbxEn && str.clrL && !str.setL) |=> lIntN);

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mbxEn |=> (lIntN && rIntN));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mbxEn && !str.setR && !str.clrR) |=> (rIntN == $past(rIntN)));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mbxEn,
  input  logic              lCe0N,
  input  logic              lCe1,
  input  logic              lOeN,
  input  logic              lRwN,
  input  logic              lBusyN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              rCe0N,
  input  logic              rCe1,
  input  logic              rOeN,
  input  logic              rRwN,
  input  logic              rBusyN,
  input  logic [ADDR_W-1:0] rAddr,
  output logic              lMemWe,
  output logic              rMemWe,
  output logic              lIntN,
  output logic              rIntN
);
  mbxStrobe_t str;
  logic [1:0] memWe;

  mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .mbxEn(mbxEn),
    .ce0N ({rCe0N, lCe0N}),
    .ce1  ({rCe1, lCe1}),
    .oeN  ({rOeN, lOeN}),
    .rwN  ({rRwN, lRwN}),
    .busyN({rBusyN, lBusyN}),
    .addr ({rAddr, lAddr}),
    .memWe(memWe),
    .str  (str)
  );

  mbx_flags u_flags (
    .clk  (clk),
    .rstN (rstN),
    .mbxEn(mbxEn),
    .str  (str),
    .lIntN(lIntN),
    .rIntN(rIntN)
  );

  assign lMemWe = memWe[SIDE_L];
  assign rMemWe = memWe[SIDE_R];
endmodule

// File: tb/sim_mbx_irq.sv
module sim_mbx_irq;
  localparam int CLK_T  = 10;
  localparam int ADDR_W = 19;
  localparam logic [ADDR_W-1:0] TOPA = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LOWA = TOPA ^ ADDR_W'(1);

  logic clk = 0, rstN = 0, mbxEn = 1;
  logic lCe0N, lCe1, lOeN, lRwN, lBusyN;
  logic rCe0N, rCe1, rOeN, rRwN, rBusyN;
  logic [ADDR_W-1:0] lAddr, rAddr;
  logic lMemWe, rMemWe, lIntN, rIntN;

  typedef struct {
    logic  lInt, rInt, lWe, rWe;
    string tag;
  } expT;
  expT q[$];

  int compared = 0, mismatched = 0;
  bit armed = 0, done = 0;
  logic pendL = 0, pendR = 0;

  always #(CLK_T/2) clk = ~clk;

  mbx_irq #(.ADDR_W(ADDR_W)) u0 (.*);

  task automatic idle();
    lCe0N = 1; lCe1 = 0; lOeN = 1; lRwN = 1; lBusyN = 1; lAddr = '0;
    rCe0N = 1; rCe1 = 0; rOeN = 1; rRwN = 1; rBusyN = 1; rAddr = '0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Driver: inputs are set at a negedge; model the edge and queue the outcome
  task automatic step(string tag);
    expT e;
    logic selL, selR, weL, weR, postL, postR, drainL, drainR;
    selL = !lCe0N && lCe1;  selR = !rCe0N && rCe1;
    weL = selL && !lRwN && lBusyN;  weR = selR && !rRwN && rBusyN;
    postL = weL && lAddr == TOPA;   postR = weR && rAddr == LOWA;
    drainL = selL && !lOeN && lAddr == LOWA;
    drainR = selR && !rOeN && rAddr == TOPA;
    pendL = !mbxEn ? 1'b0 : postR ? 1'b1 : drainL ? 1'b0 : pendL;
    pendR = !mbxEn ? 1'b0 : postL ? 1'b1 : drainR ? 1'b0 : pendR;
    e.lInt = !pendL; e.rInt = !pendR; e.lWe = weL; e.rWe = weR; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: just after each edge, compare against the queue head
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (armed && q.size() > 0) begin
        expT e;
        e = q.pop_front();
        compared++;
        if ({lIntN, rIntN, lMemWe, rMemWe} !== {e.lInt, e.rInt, e.lWe, e.rWe}) begin
          mismatched++;
          $display("FAIL %s: got lInt=%b rInt=%b lWe=%b rWe=%b exp %b %b %b %b",
                   e.tag, lIntN, rIntN, lMemWe, rMemWe, e.lInt, e.rInt, e.lWe, e.rWe);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout exp completion");
    finish();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    compared++;
    if (lIntN !== 1'b1 || rIntN !== 1'b1) begin
      mismatched++;
      $display("FAIL R1: got %b %b exp 1 1", lIntN, rIntN);
    end
    armed = 1;
    // R10 R11 ordinary write
    idle(); lCe0N = 0; lCe1 = 1; lRwN = 0; lAddr = 'h10; step("R10_R11");
    // R2 right posts to left
    idle(); rCe0N = 0; rCe1 = 1; rRwN = 0; rAddr = LOWA; step("R2");
    // R12 hold
    idle(); step("R12");
    // R7 selected but output enable off
    idle(); lCe0N = 0; lCe1 = 1; lAddr = LOWA; step("R7");
    // R3 clear with rw low (write)
    idle(); lCe0N = 0; lCe1 = 1; lOeN = 0; lRwN = 0; lAddr = LOWA; step("R3_rw0");
    // set again, then clear with plain read
    idle(); rCe0N = 0; rCe1 = 1; rRwN = 0; rAddr = LOWA; step("R2_again");
    idle(); lCe0N = 0; lCe1 = 1; lOeN = 0; lAddr = LOWA; step("R3_read");
    // R4 left posts to right, right collects
    idle(); lCe0N = 0; lCe1 = 1; lRwN = 0; lAddr = TOPA; step("R4_set");
    idle(); rCe0N = 0; rCe1 = 1; rOeN = 0; rAddr = LOWA; step("R4_wrongaddr");
    idle(); rCe0N = 0; rCe1 = 1; rOeN = 0; rAddr = TOPA; step("R4_clr");
    // R5 unselected writes
    idle(); rCe0N = 0; rCe1 = 0; rRwN = 0; rAddr = LOWA; step("R5_ce1");
    idle(); rCe0N = 1; rCe1 = 1; rRwN = 0; rAddr = LOWA; step("R5_ce0");
    // R6 busy write
    idle(); rCe0N = 0; rCe1 = 1; rRwN = 0; rBusyN = 0; rAddr = LOWA; step("R6");
    idle(); lCe0N = 0; lCe1 = 1; lRwN = 0; lBusyN = 0; lAddr = TOPA; step("R6_left");
    // R8 set and clear together
    idle(); rCe0N = 0; rCe1 = 1; rRwN = 0; rAddr = LOWA;
    lCe0N = 0; lCe1 = 1; lOeN = 0; lAddr = LOWA; step("R8");
    // R11 right writes its own mailbox
    idle(); rCe0N = 0; rCe1 = 1; rRwN = 0; rAddr = TOPA; step("R11");
    // R9 disable clears and blocks setting, storage still written
    idle(); mbxEn = 0; step("R9_drop");
    idle(); rCe0N = 0; rCe1 = 1; rRwN = 0; rAddr = LOWA; step("R9_noset");
    idle(); lCe0N = 0; lCe1 = 1; lRwN = 0; lAddr = TOPA; step("R9_noset_r");
    idle(); mbxEn = 1; step("R9_reenable");
    idle(); step("R12_idle");
    @(negedge clk);
    finish();
  end
endmodule